// File: doc/BRIEF.md
# Condition Flags and Predicate Unit

This block keeps the four arithmetic status flags of a 32-bit load-store processor: negative, zero, carry and overflow. Each instruction arrives with a 4-bit condition field. The block compares that field with the current flags and decides in the same cycle whether the instruction executes or is squashed. It also reports whether a destination register may be written.

When an instruction executes, the flags are updated at the next clock edge in three cases: the instruction is a compare/test, its set-flags bit is raised, or it restores a saved status copy. A compare/test always refreshes the flags and never writes a result. An ordinary operation touches the flags only when its set-flags bit is asserted. An ordinary operation that sets flags and targets the program counter loads the flags from the saved copy instead of deriving them from the result.

Top module: `cond_flag_unit`

## Requirements
- R1: After reset, `flags_o` is 4'b0000. The bit order is {N,Z,C,V}, with N in bit 3 and V in bit 0.
- R2: Codes 0 to 7 each test one flag, in pairs where the even code tests for 1 and the odd code tests for 0. Codes 0/1 test Z, 2/3 test C, 4/5 test N and 6/7 test V.
- R3: Code 8 passes when C=1 and Z=0. Code 9 passes when C=0 or Z=1.
- R4: Code 10 passes when N==V. Code 11 passes when N!=V. Code 12 passes when Z=0 and N==V. Code 13 passes when Z=1 or N!=V.
- R5: Code 14 always passes and code 15 never passes. `exec_o` is `valid_i` AND the predicate result, and it is combinational from the current flags.
- R6: An executed ordinary operation (`kind_i[1]`=0) with `setf_i`=0 leaves the flags unchanged.
- R7: A compare/test (`kind_i[1]`=1) that executes updates the flags whatever the value of `setf_i`. It also holds `rd_we_o` at 0. For other executed operations, `rd_we_o` equals `exec_o`.
- R8: An arithmetic flag update (`kind_i[0]`=0) sets N to bit 31 of the result and Z to 1 when the result is zero. It sets C from `carry_i` and V from `ovf_i`.
- R9: A logical flag update (`kind_i[0]`=1) sets N and Z as in R8, sets C from `shift_c_i`, and keeps V unchanged.
- R10: An executed ordinary operation with `setf_i`=1 and `dst_pc_i`=1 loads the flags from `saved_i` ({N,Z,C,V}).
- R11: A squashed instruction (predicate false) does not change the flags, even when `setf_i` is 1. It also keeps `rd_we_o` at 0.
- R12: When `valid_i` is 0, `exec_o` and `rd_we_o` are 0 and the flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | An instruction is present this cycle |
| cond_i | input | 4 | Condition field of the instruction |
| kind_i | input | 2 | Bit 1: compare/test. Bit 0: logical (selects shifter carry and keeps V) |
| setf_i | input | 1 | Set-flags request of an ordinary operation |
| dst_pc_i | input | 1 | Destination is the program counter |
| result_i | input | 32 | ALU result |
| carry_i | input | 1 | Adder carry-out |
| ovf_i | input | 1 | Adder signed overflow |
| shift_c_i | input | 1 | Shifter carry-out |
| saved_i | input | 4 | Saved status copy, {N,Z,C,V} |
| flags_o | output | 4 | Current flags, {N,Z,C,V} |
| exec_o | output | 1 | Instruction executes |
| rd_we_o | output | 1 | Destination register write allowed |

## Verification
`exec_o` and `rd_we_o` are combinational, so they are checked one time unit after the inputs are driven, inside the cycle. Flag changes appear only after the next rising edge. The driver therefore queues each expected flag value, and the monitor compares it on the following falling edge, one full cycle after the stimulus. Every one of the sixteen codes is swept against all sixteen flag patterns. Each pattern is loaded through the restore path first, so that the restore and the predicate logic are exercised together.

// File: rtl/cond_flag_unit.sv
module cond_flag_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [3:0]   cond_i,
  input  logic [1:0]   kind_i,
  input  logic         setf_i,
  input  logic         dst_pc_i,
  input  logic [W-1:0] result_i,
  input  logic         carry_i,
  input  logic         ovf_i,
  input  logic         shift_c_i,
  input  logic [3:0]   saved_i,
  output logic [3:0]   flags_o,
  output logic         exec_o,
  output logic         rd_we_o
);
  logic n, z, c, v;
  logic pass, base;
  logic [3:0] calc;

  assign {n, z, c, v} = flags_o;

  always_comb begin
    case (cond_i[3:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c & ~z;
      3'd5: base = n ~^ v;
      3'd6: base = ~z & (n ~^ v);
      default: base = 1'b1;
    endcase
    pass = cond_i[0] ? ~base : base;
  end

  assign exec_o  = valid_i & pass;
  assign rd_we_o = exec_o & ~kind_i[1];

  assign calc = {result_i[W-1], ~|result_i,
                 kind_i[0] ? shift_c_i : carry_i,
                 kind_i[0] ? v : ovf_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      flags_o <= 4'b0000;
    else if (exec_o) begin
      if (kind_i[1])
        flags_o <= calc;
      else if (setf_i)
        flags_o <= dst_pc_i ? saved_i : calc;
    end
endmodule

module cond_flag_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid_i,
  input logic [3:0]  cond_i,
  input logic [1:0]  kind_i,
  input logic        setf_i,
  input logic        dst_pc_i,
  input logic [31:0] result_i,
  input logic [3:0]  saved_i,
  input logic [3:0]  flags_o,
  input logic        exec_o,
  input logic        rd_we_o
);
  a_r11_squash_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !exec_o) |=> $stable(flags_o));
  a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    kind_i[1] |-> !rd_we_o);
  a_r5_never: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == 4'hF) |-> !exec_o);
  a_r5_always: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && cond_i == 4'hE) |-> exec_o);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o && !kind_i[1] && !setf_i) |=> $stable(flags_o));
  a_r10_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o && !kind_i[1] && setf_i && dst_pc_i) |=> flags_o == $past(saved_i));
  a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o && kind_i[1]) |=> flags_o[2] == ($past(result_i) == 32'd0));
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> (!exec_o && !rd_we_o));
endmodule

bind cond_flag_unit cond_flag_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .cond_i(cond_i),
  .kind_i(kind_i), .setf_i(setf_i), .dst_pc_i(dst_pc_i),
  .result_i(result_i), .saved_i(saved_i), .flags_o(flags_o),
  .exec_o(exec_o), .rd_we_o(rd_we_o));

// File: tb/test_cond_flag_unit.sv
module test_cond_flag_unit;
  logic clk = 0, rst_n = 0;
  logic valid_i = 0, setf_i = 0, dst_pc_i = 0, carry_i = 0, ovf_i = 0, shift_c_i = 0;
  logic [3:0] cond_i = 0, saved_i = 0;
  logic [1:0] kind_i = 0;
  logic [31:0] result_i = 0;
  logic [3:0] flags_o;
  logic exec_o, rd_we_o;

  int errors = 0, checks = 0;
  logic [3:0] mf = 4'b0000;

  typedef struct { logic [3:0] f; string tag; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  cond_flag_unit i_cond_flag_unit (.*);

  function automatic logic cond_ok(input logic [3:0] cc, input logic [3:0] f);
    logic nn, zz, cy, vv;
    {nn, zz, cy, vv} = f;
    case (cc)
      4'd0:  return zz;
      4'd1:  return !zz;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return nn;
      4'd5:  return !nn;
      4'd6:  return vv;
      4'd7:  return !vv;
      4'd8:  return cy && !zz;
      4'd9:  return !cy || zz;
      4'd10: return nn == vv;
      4'd11: return nn != vv;
      4'd12: return !zz && nn == vv;
      4'd13: return zz || nn != vv;
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic vld, input logic [3:0] cc, input logic [1:0] k,
                       input logic sf, input logic pc, input logic [31:0] res,
                       input logic cy, input logic ov, input logic sc,
                       input logic [3:0] sv, input string ftag);
    logic ok, ee;
    string etag;
    @(negedge clk);
    valid_i = vld; cond_i = cc; kind_i = k; setf_i = sf; dst_pc_i = pc;
    result_i = res; carry_i = cy; ovf_i = ov; shift_c_i = sc; saved_i = sv;
    ok = cond_ok(cc, mf);
    ee = vld && ok;
    etag = !vld ? "R12" : cc < 8 ? "R2" : cc < 10 ? "R3" : cc < 14 ? "R4" : "R5";
    #1;
    check({etag, " exec"}, {3'b0, exec_o}, {3'b0, ee});
    check({(ee || !vld) ? "R7" : "R11", " rd_we"}, {3'b0, rd_we_o}, {3'b0, ee && !k[1]});
    if (ee && (k[1] || sf)) begin
      if (!k[1] && pc) mf = sv;
      else mf = {res[31], res == 32'd0, k[0] ? sc : cy, k[0] ? mf[0] : ov};
    end
    sb.push_back('{mf, ftag});
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " flags"}, flags_o, it.f);
      end
    end
  end

  initial begin
    #20000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1 check("R1 reset", flags_o, 4'b0000);
    rst_n = 1;
    // R7/R8: compare arith, setf low, zero result with carry
    drive(1, 4'hE, 2'b10, 0, 0, 32'd0, 1, 0, 0, 4'h0, "R7 R8");
    // R8: negative with overflow via compare
    drive(1, 4'hE, 2'b10, 0, 0, 32'h8000_0001, 0, 1, 0, 4'h0, "R8");
    // R9: logical compare, V kept at 1, C from shifter
    drive(1, 4'hE, 2'b11, 0, 0, 32'h0000_0010, 1, 0, 1, 4'h0, "R9");
    // R9: ordinary logical with setf
    drive(1, 4'hE, 2'b01, 1, 0, 32'h0, 0, 0, 0, 4'h0, "R9");
    // R6: ordinary arith without setf
    drive(1, 4'hE, 2'b00, 0, 0, 32'h8000_0000, 1, 1, 0, 4'h0, "R6");
    // R11: never code with setf; EQ fails when Z clear
    drive(1, 4'hF, 2'b00, 1, 0, 32'h0, 1, 1, 1, 4'h0, "R11");
    drive(1, 4'hE, 2'b00, 1, 1, 32'h0, 0, 0, 0, 4'b0000, "R10");
    drive(1, 4'h0, 2'b10, 1, 0, 32'h0, 1, 1, 1, 4'h0, "R11");
    // R12: invalid compare does nothing
    drive(0, 4'hE, 2'b10, 1, 0, 32'h0, 1, 1, 1, 4'h0, "R12");
    // R2-R5 sweep: restore each pattern, then every code without setf
    for (int f = 0; f < 16; f++) begin
      drive(1, 4'hE, 2'b00, 1, 1, 32'h1, 1, 1, 1, f[3:0], "R10");
      for (int cc = 0; cc < 16; cc++)
        drive(1, cc[3:0], 2'b00, 0, 0, 32'h0, 1, 1, 1, 4'h0, "R6");
    end
    drive(1, 4'hE, 2'b00, 0, 0, 32'h0, 0, 0, 0, 4'h0, "R6");
    @(negedge clk); @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule